// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block moves a clock domain from one operating point to another. An operating point is a pair of codes: a frequency code for the PLL and a voltage ID (VID) code for the supply regulator. Software hands a new target to the block over a valid/ready request port. The block then works out the order in which to change voltage and frequency. The supply must always be high enough for the clock it feeds. When the frequency goes up, the block raises the voltage first and relocks the PLL afterwards. When the frequency goes down, it relocks the PLL first and lowers the voltage afterwards.

The VID output never jumps. It moves one code at a time, with a fixed number of clock cycles between moves. During a PLL relock the block raises a core-stall signal. This stall window is bounded by a configurable cycle limit, and a lock that arrives later than that limit raises an error flag. The request port never back-pressures: `req_ready` is always high, and a request is taken in every cycle in which `req_valid` is high. A request taken while a transition is running is parked in a one-entry slot. A later request replaces what is parked, and the parked target starts once the running transition has finished.

Top module: `vfx_sequencer`

## Requirements
- R1: While reset is asserted and right after it, `vid_out` equals RST_VID, `pll_freq` equals RST_FREQ, and `core_stall`, `pll_relock`, `xfer_done` and `lock_err` are all low.
- R2: `req_ready` is high in every cycle, including while a transition is running. A request is taken whenever `req_valid` is high, with the frequency code on `req_freq` and the VID code on `req_vid`.
- R3: When the target frequency code is greater than the current one, every VID change of that transition happens before the relock pulse.
- R4: When the target frequency code is less than the current one, the relock pulse comes first, and every VID change happens after `core_stall` has fallen.
- R5: Each VID change moves `vid_out` by exactly one code. Successive changes within a transition are exactly STEP_CYC cycles apart. A transition makes exactly |target VID − current VID| changes.
- R6: `core_stall` rises together with the relock pulse and stays high until `pll_lock` is taken. A lock level seen in the relock cycle itself is ignored. `vid_out` does not change while `core_stall` is high.
- R7: `lock_err` goes high when `core_stall` has stayed high for more than LOCK_MAX cycles. It stays high until the next relock pulse, which clears it.
- R8: A request taken while a transition runs is started only after that transition's done pulse. Of several such requests, only the last one is carried out.
- R9: A target whose frequency code equals the current one causes no relock. A target equal to the current operating point finishes with no relock and no VID change.
- R10: `xfer_done` pulses for one cycle at the end of each transition. At that point `vid_out` and `pll_freq` equal the target codes.
- R11: `pll_relock` is a one-cycle pulse, and `pll_freq` carries the new frequency code in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Target request is present |
| req_ready | output | 1 | Request accepted (always high) |
| req_freq | input | FREQ_W | Target frequency code |
| req_vid | input | VID_W | Target VID code |
| vid_out | output | VID_W | VID code driven to the regulator |
| pll_relock | output | 1 | One-cycle relock command to the PLL |
| pll_freq | output | FREQ_W | Frequency code commanded to the PLL |
| pll_lock | input | 1 | PLL lock level |
| core_stall | output | 1 | Core unavailable while the PLL relocks |
| xfer_done | output | 1 | One-cycle pulse at the end of a transition |
| lock_err | output | 1 | Stall window exceeded LOCK_MAX cycles |

## Verification
The bench first runs an ascending sweep over every frequency code and then a descending one. Each step picks a different VID distance and PLL lock delay. The upward steps show that the voltage moves before the relock, and the downward steps show that it moves after the relock. The lock delays fall on both sides of LOCK_MAX, so the error flag is seen both rising and being cleared. Targets with the same frequency code, and a target equal to the current operating point, show that no relock is issued when none is needed. A burst of three requests sent during a long ramp shows that the middle request is replaced by the last one, and that the last one waits for the first transition to finish.

// File: rtl/vfx_pkg.sv
package vfx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_VPRE  = 2'd1,
    ST_LOCK  = 2'd2,
    ST_VPOST = 2'd3
  } vfx_state_e;
endpackage

// File: rtl/vfx_req_slot.sv
module vfx_req_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] data
);
  logic         valid_q;
  logic [W-1:0] data_q;

  // A push in the same cycle as a pop wins, so the newest target is kept.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (push) begin
        valid_q <= 1'b1;
        data_q  <= push_data;
      end else if (pop) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
endmodule

// File: rtl/vfx_vid_ramp.sv
module vfx_vid_ramp #(
  parameter int VID_W    = 5,
  parameter int STEP_CYC = 3,
  parameter int RST_VID  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [VID_W-1:0] tgt,
  output logic [VID_W-1:0] vid,
  output logic             at_tgt
);
  logic [VID_W-1:0] vid_q;
  logic             tick;

  assign at_tgt = (vid_q == tgt);

  generate
    if (STEP_CYC <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(STEP_CYC);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (!en || at_tgt)              cnt_q <= '0;
        else if (cnt_q == CW'(STEP_CYC - 1)) cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == CW'(STEP_CYC - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)
      vid_q <= VID_W'(RST_VID);
    else if (en && !at_tgt && tick)
      vid_q <= (tgt > vid_q) ? vid_q + VID_W'(1) : vid_q - VID_W'(1);
  end

  assign vid = vid_q;
endmodule

// File: rtl/vfx_lock_watch.sv
module vfx_lock_watch #(
  parameter int LOCK_MAX = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic lock_ok,
  output logic err
);
  localparam int CW = $clog2(LOCK_MAX + 1);
  logic [CW-1:0] cnt_q;
  logic          err_q;

  // cnt_q holds the number of stall cycles already spent without lock.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (active && !lock_ok) begin
      if (cnt_q != CW'(LOCK_MAX))     cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(LOCK_MAX - 1)) err_q <= 1'b1;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/vfx_sequencer.sv
module vfx_sequencer #(
  parameter int FREQ_W   = 4,
  parameter int VID_W    = 5,
  parameter int STEP_CYC = 3,
  parameter int LOCK_MAX = 6,
  parameter int RST_FREQ = 0,
  parameter int RST_VID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREQ_W-1:0] req_freq,
  input  logic [VID_W-1:0]  req_vid,
  output logic [VID_W-1:0]  vid_out,
  output logic              pll_relock,
  output logic [FREQ_W-1:0] pll_freq,
  input  logic              pll_lock,
  output logic              core_stall,
  output logic              xfer_done,
  output logic              lock_err
);
  import vfx_pkg::*;

  localparam int OP_W = FREQ_W + VID_W;

  vfx_state_e        state_q, state_d;
  logic [FREQ_W-1:0] freq_q, tgt_freq_q, slot_freq, lock_freq;
  logic [VID_W-1:0]  tgt_vid_q, slot_vid;
  logic [OP_W-1:0]   slot_data;
  logic              slot_valid, pop;
  logic              relock_q, done_q;
  logic              enter_lock, finish, accept, ramp_en, at_tgt;

  assign req_ready = 1'b1;

  vfx_req_slot #(.W(OP_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (req_valid),
    .push_data ({req_freq, req_vid}),
    .pop       (pop),
    .valid     (slot_valid),
    .data      (slot_data)
  );

  assign {slot_freq, slot_vid} = slot_data;
  assign pop = (state_q == ST_IDLE) && slot_valid;

  assign ramp_en = (state_q == ST_VPRE) || (state_q == ST_VPOST);

  vfx_vid_ramp #(.VID_W(VID_W), .STEP_CYC(STEP_CYC), .RST_VID(RST_VID)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (ramp_en),
    .tgt    (tgt_vid_q),
    .vid    (vid_out),
    .at_tgt (at_tgt)
  );

  // The lock level is not trusted in the cycle of the relock pulse itself.
  assign accept = (state_q == ST_LOCK) && pll_lock && !relock_q;

  vfx_lock_watch #(.LOCK_MAX(LOCK_MAX)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (enter_lock),
    .active  (state_q == ST_LOCK),
    .lock_ok (accept),
    .err     (lock_err)
  );

  always_comb begin
    state_d    = state_q;
    enter_lock = 1'b0;
    finish     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (slot_valid) begin
          if (slot_freq > freq_q) begin
            state_d = ST_VPRE;
          end else if (slot_freq < freq_q) begin
            state_d    = ST_LOCK;
            enter_lock = 1'b1;
          end else if (slot_vid != vid_out) begin
            state_d = ST_VPOST;
          end else begin
            finish = 1'b1;
          end
        end
      end
      ST_VPRE: begin
        if (at_tgt) begin
          state_d    = ST_LOCK;
          enter_lock = 1'b1;
        end
      end
      ST_LOCK: begin
        if (accept) begin
          if (at_tgt) begin
            state_d = ST_IDLE;
            finish  = 1'b1;
          end else begin
            state_d = ST_VPOST;
          end
        end
      end
      ST_VPOST: begin
        if (at_tgt) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign lock_freq = (state_q == ST_IDLE) ? slot_freq : tgt_freq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      freq_q     <= FREQ_W'(RST_FREQ);
      tgt_freq_q <= FREQ_W'(RST_FREQ);
      tgt_vid_q  <= VID_W'(RST_VID);
      relock_q   <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      relock_q <= enter_lock;
      done_q   <= finish;
      if (pop) begin
        tgt_freq_q <= slot_freq;
        tgt_vid_q  <= slot_vid;
      end
      if (enter_lock) freq_q <= lock_freq;
    end
  end

  assign pll_relock = relock_q;
  assign pll_freq   = freq_q;
  assign core_stall = (state_q == ST_LOCK);
  assign xfer_done  = done_q;
endmodule

// File: rtl/vfx_sequencer_chk.sv
module vfx_sequencer_chk #(
  parameter int VID_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VID_W-1:0] vid_out,
  input logic             pll_relock,
  input logic             core_stall,
  input logic             xfer_done,
  input logic             lock_err
);
  a_r5_one_code_step: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_out != $past(vid_out)) |->
      (vid_out == VID_W'($past(vid_out) + 1'b1) || vid_out == VID_W'($past(vid_out) - 1'b1)));

  a_r6_vid_frozen_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && $past(core_stall)) |-> $stable(vid_out));

  a_r6_stall_with_relock: assert property (@(posedge clk) disable iff (!rst_n)
    pll_relock |-> core_stall);

  a_r11_relock_single: assert property (@(posedge clk) disable iff (!rst_n)
    pll_relock |=> !pll_relock);

  a_r7_err_rises_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_err) |-> core_stall);

  a_r10_done_not_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !core_stall);
endmodule

bind vfx_sequencer vfx_sequencer_chk #(.VID_W(VID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vid_out    (vid_out),
  .pll_relock (pll_relock),
  .core_stall (core_stall),
  .xfer_done  (xfer_done),
  .lock_err   (lock_err)
);

// File: tb/test_vfx_sequencer.sv
module test_vfx_sequencer;
  localparam int FREQ_W = 4, VID_W = 5, STEP_CYC = 3, LOCK_MAX = 6;
  localparam int RST_FREQ = 0, RST_VID = 0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [FREQ_W-1:0] req_freq = '0;
  logic [VID_W-1:0]  req_vid = '0;
  logic [VID_W-1:0]  vid_out;
  logic pll_relock, core_stall, xfer_done, lock_err;
  logic [FREQ_W-1:0] pll_freq;
  logic pll_lock = 1'b1;

  always #5 clk = ~clk;

  vfx_sequencer #(.FREQ_W(FREQ_W), .VID_W(VID_W), .STEP_CYC(STEP_CYC), .LOCK_MAX(LOCK_MAX),
                  .RST_FREQ(RST_FREQ), .RST_VID(RST_VID)) i_vfx_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_freq(req_freq), .req_vid(req_vid), .vid_out(vid_out), .pll_relock(pll_relock),
    .pll_freq(pll_freq), .pll_lock(pll_lock), .core_stall(core_stall),
    .xfer_done(xfer_done), .lock_err(lock_err));

  // PLL stub: drops lock on a relock and raises it again lock_dly cycles later.
  int lock_dly = 1;
  int lcnt = 0;
  always @(posedge clk) begin
    if (pll_relock) begin
      pll_lock <= 1'b0;
      lcnt     <= lock_dly;
    end else if (!pll_lock) begin
      if (lcnt <= 1) pll_lock <= 1'b1;
      else           lcnt <= lcnt - 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Event monitor, sampled at the falling edge.
  int cyc = 0, done_cnt = 0, relock_cnt = 0, relock_f = 0, stall_len = 0;
  int bad_step = 0, bad_gap = 0, vid_in_stall = 0, pre_cnt = 0, post_cnt = 0, last_chg = 0;
  bit have_last = 0;
  int prev_vid = RST_VID;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (xfer_done) done_cnt++;
      if (pll_relock) begin relock_cnt++; relock_f = int'(pll_freq); end
      if (core_stall) stall_len++;
      if (int'(vid_out) != prev_vid) begin
        if (int'(vid_out) - prev_vid != 1 && prev_vid - int'(vid_out) != 1) bad_step++;
        if (core_stall) vid_in_stall++;
        if (relock_cnt == 0) pre_cnt++; else post_cnt++;
        if (have_last && cyc - last_chg != STEP_CYC) bad_gap++;
        last_chg  = cyc;
        have_last = 1;
      end
    end
    prev_vid = int'(vid_out);
  end

  task automatic clear_mon();
    done_cnt = 0; relock_cnt = 0; stall_len = 0; bad_step = 0; bad_gap = 0;
    vid_in_stall = 0; pre_cnt = 0; post_cnt = 0; have_last = 0;
  endtask

  task automatic send(input int f, input int v);
    @(posedge clk); #2;
    req_valid = 1'b1; req_freq = FREQ_W'(f); req_vid = VID_W'(v);
    chk("R2 ready while requesting", int'(req_ready), 1);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int n);
    for (int k = 0; k < 3000 && done_cnt < n; k++) @(negedge clk);
    for (int k = 0; k < 6; k++) @(negedge clk);
  endtask

  int cur_f = RST_FREQ, cur_v = RST_VID;
  bit exp_err = 0;

  task automatic run_txn(input int f, input int v, input int d);
    int steps, rl;
    lock_dly = d;
    @(posedge clk); #2; clear_mon();
    send(f, v);
    wait_done(1);
    steps = (v > cur_v) ? v - cur_v : cur_v - v;
    rl = (f != cur_f) ? 1 : 0;
    if (rl) exp_err = (d + 2 > LOCK_MAX);
    chk("R10 one done pulse", done_cnt, 1);
    chk("R10 vid at target", int'(vid_out), v);
    chk("R10 pll_freq at target", int'(pll_freq), f);
    chk("R9 relock only on freq change", relock_cnt, rl);
    chk("R5 number of VID changes", pre_cnt + post_cnt, steps);
    chk("R5 single-code steps", bad_step, 0);
    chk("R5 step spacing", bad_gap, 0);
    chk("R6 VID frozen in stall", vid_in_stall, 0);
    chk("R6 stall length", stall_len, rl ? d + 2 : 0);
    chk("R7 lock error flag", int'(lock_err), int'(exp_err));
    if (rl) chk("R11 relock carries new code", relock_f, f);
    if (f > cur_f) chk("R3 no VID change after relock", post_cnt, 0);
    if (f < cur_f) chk("R4 no VID change before relock", pre_cnt, 0);
    cur_f = f; cur_v = v;
  endtask

  bit wd_hit = 0;
  initial begin
    #(10 * 150000);
    wd_hit = 1;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    chk("R1 reset vid", int'(vid_out), RST_VID);
    chk("R1 reset freq", int'(pll_freq), RST_FREQ);
    chk("R1 reset stall", int'(core_stall), 0);
    chk("R1 reset relock", int'(pll_relock), 0);
    chk("R1 reset done", int'(xfer_done), 0);
    chk("R1 reset err", int'(lock_err), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 idle after reset", int'(core_stall) + int'(xfer_done) + int'(lock_err), 0);

    for (int f = 1; f < 16; f++) run_txn(f, (f * 7 + 3) % 32, 1 + (f % 7));
    for (int f = 14; f >= 0; f--) run_txn(f, (f * 5 + 11) % 32, 1 + ((f + 3) % 7));

    // R9: same frequency, other VID; then the very same operating point.
    run_txn(cur_f, (cur_v + 3) % 32, 2);
    run_txn(cur_f, cur_v, 2);
    run_txn(cur_f, cur_v, 6);

    // R8: burst during a long ramp; the middle request is overwritten.
    run_txn(0, 0, 1);
    lock_dly = 2;
    @(posedge clk); #2; clear_mon();
    send(12, 30);
    repeat (10) @(posedge clk);
    chk("R8 first transition still running", done_cnt, 0);
    send(3, 0);
    send(7, 5);
    chk("R8 deferred, no early done", done_cnt, 0);
    wait_done(2);
    chk("R8 two transitions only", done_cnt, 2);
    chk("R8 two relocks", relock_cnt, 2);
    chk("R8 last relock to newest code", relock_f, 7);
    chk("R8 final vid", int'(vid_out), 5);
    chk("R8 final freq", int'(pll_freq), 7);

    if (!wd_hit) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule